// File: doc/BRIEF.md
# Host/Device Shared Mailbox Register File

This block is a small bank of eight byte-wide registers that two independent bus agents share. One agent is the host, usually a bridge from a link to a computer. The other is the device logic on the same chip. Each agent has its own Wishbone Rev B.3 slave port with a 3-bit address. The bank gives the two sides a simple way to talk to each other:

- a byte that either side can read or write;
- eight interrupt-style flag lines that the host raises and the device acknowledges;
- a view of the board switches, which either side can read;
- registers for the LEDs and four seven-segment digit patterns, which either side can write.

A status register holds two bits: a hold-in-reset line for the device and a memory-ownership select. It is read-only on both ports. Its content follows two dedicated inputs, one clock behind them. Reset forces it to "device held, host owns memory".

Every register output is brought to a port, so that surrounding logic can drive the display, the LEDs and the interrupt inputs. When both ports write the same register in the same cycle, the host port wins.

Top module: `hostdev_mailbox`

Register offsets (3-bit address on either port):

| Offset | Contents |
|---|---|
| 0 | Status: bit 7 is the device hold, bit 6 is memory owned by host, bits 5..0 read as 0 |
| 1 | Flags |
| 2 | Shared byte |
| 3 | Reads the switches, writes the LEDs |
| 4 to 7 | Digits 0 to 3 |

## Requirements
- R1: While reset is high, and on the first cycle after it, the flags, shared byte, LEDs and all digit bytes read 0. `dev_hold_o` and `host_mem_o` are both 1. Neither ack is asserted.
- R2: A port asserts its ack on the clock after it first samples cyc and stb both high. The ack lasts one cycle per access and is low whenever stb or cyc is low. Read data on `*_dat_o` is valid while ack is high.
- R3: The status register at offset 0 reads as {hold, host_mem, 000000}. In the cycle after each non-reset clock, bit 7 equals `ctl_hold_i` and bit 6 equals `ctl_host_mem_i` from that clock. Writes to offset 0 from either port change nothing.
- R4: A host write to offset 1 sets every flag bit written as 1 and leaves bits written as 0 unchanged. `irq_o` shows the flags from the clock of the write onward.
- R5: A device write to offset 1 clears every flag bit written as 1 and leaves bits written as 0 unchanged. Flags change only through such writes.
- R6: When a host set and a device clear of offset 1 happen in the same cycle, the result is (old AND NOT clear) OR set. A set therefore beats a clear on the same bit.
- R7: The shared byte at offset 2 is readable and writable from both ports. A simultaneous write from both ports to any writable register stores the host value.
- R8: Writes to offset 3 load `led_o`. Reads of offset 3 return `sw_i` after a two-flop synchroniser, so a change becomes readable at the third clock after it.
- R9: Offsets 4 to 7 hold digits 0 to 3. Digit n drives `digit_o[8n+7:8n]`, where digit 0 is the rightmost. Each digit reads back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| hst_cyc_i | input | 1 | Host port cycle |
| hst_stb_i | input | 1 | Host port strobe |
| hst_we_i | input | 1 | Host port write enable |
| hst_adr_i | input | 3 | Host port register offset |
| hst_dat_i | input | 8 | Host port write data |
| hst_dat_o | output | 8 | Host port read data |
| hst_ack_o | output | 1 | Host port acknowledge |
| dev_cyc_i | input | 1 | Device port cycle |
| dev_stb_i | input | 1 | Device port strobe |
| dev_we_i | input | 1 | Device port write enable |
| dev_adr_i | input | 3 | Device port register offset |
| dev_dat_i | input | 8 | Device port write data |
| dev_dat_o | output | 8 | Device port read data |
| dev_ack_o | output | 1 | Device port acknowledge |
| ctl_hold_i | input | 1 | Next value of the device-hold status bit |
| ctl_host_mem_i | input | 1 | Next value of the memory-owner status bit |
| sw_i | input | 8 | Switch positions, asynchronous |
| dev_hold_o | output | 1 | Hold-in-reset line to the device, active high |
| host_mem_o | output | 1 | 1 when the host owns memory |
| irq_o | output | 8 | Flag lines, host to device |
| led_o | output | 8 | LED drive |
| digit_o | output | 32 | Four active-low segment patterns (bits 0 to 6 are segments a to g, bit 7 is the point) |

## Verification
The assertions check the following on every clock:

- ack only appears while a strobed cycle is present, and only after a request in the previous cycle;
- flag bits set by the host are present on the next cycle;
- flag bits cleared by the device alone are gone on the next cycle;
- the flags hold still when no flag write occurs;
- the two status bits trail their inputs by one clock;
- an LED write lands on `led_o`.

The bench scenarios cover the rest:

- read-back through both ports;
- the set-beats-clear and host-wins collisions;
- the three-clock visibility of the switches;
- the digit byte placement;
- the immunity of offset 0 to writes.

// File: rtl/hdmbx_pkg.sv
package hdmbx_pkg;
   // Register offsets whose positions the read mux and write decode depend on
   localparam int OFS_STATUS = 0;
   localparam int OFS_FLAGS  = 1;
   localparam int OFS_SHARED = 2;
   localparam int OFS_IO     = 3;
   localparam int OFS_DIGIT0 = 4;

   // Reset value of the two status bits: {device hold, host owns memory}
   localparam logic [1:0] STATUS_RST = 2'b11;

   typedef struct packed {
      logic hold;
      logic host_mem;
   } status_t;
endpackage

// File: rtl/hdmbx_sync.sv
module hdmbx_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hdmbx_sync needs at least two stages");
   end
   if (W < 1) begin : g_bad_width
      $error("hdmbx_sync width must be positive");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            chain[s] <= '0;
         end else begin
            chain[s] <= (s == 0) ? d_i : chain[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/hdmbx_port.sv
module hdmbx_port #(
   parameter int DW = 8
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic          cyc_i,
   input  logic          stb_i,
   input  logic          we_i,
   input  logic [DW-1:0] rd_val_i,
   output logic [DW-1:0] dat_o,
   output logic          ack_o,
   output logic          wr_go_o
);
   logic          ack_q;
   logic          start;
   logic [DW-1:0] rdat_q;

   // ack is gated by the live strobe so it falls as soon as stb does
   assign ack_o   = ack_q & cyc_i & stb_i;
   assign start   = cyc_i & stb_i & ~ack_o;
   assign wr_go_o = start & we_i;
   assign dat_o   = rdat_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         ack_q  <= 1'b0;
         rdat_q <= '0;
      end else begin
         ack_q <= start;
         if (start) begin
            rdat_q <= rd_val_i;
         end
      end
   end
endmodule

// File: rtl/hdmbx_regs.sv
module hdmbx_regs
   import hdmbx_pkg::*;
#(
   parameter int DW   = 8,
   parameter int NDIG = 4,
   parameter int AW   = 3
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              h_wr_i,
   input  logic [AW-1:0]     h_adr_i,
   input  logic [DW-1:0]     h_wd_i,
   input  logic              d_wr_i,
   input  logic [AW-1:0]     d_adr_i,
   input  logic [DW-1:0]     d_wd_i,
   input  logic [DW-1:0]     sw_sync_i,
   input  status_t           status_nxt_i,
   output status_t           status_o,
   output logic [DW-1:0]     flags_o,
   output logic [DW-1:0]     led_o,
   output logic [NDIG*DW-1:0] digit_o,
   output logic [DW-1:0]     h_rval_o,
   output logic [DW-1:0]     d_rval_o
);
   localparam int NREG = OFS_DIGIT0 + NDIG;

   status_t       status_q;
   logic [DW-1:0] flags_q;
   logic [DW-1:0] store [OFS_SHARED:NREG-1];
   logic [DW-1:0] view  [NREG];
   logic [DW-1:0] set_mask;
   logic [DW-1:0] clr_mask;

   // Status bits follow their inputs; neither bus port can reach them
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         status_q <= status_t'(STATUS_RST);
      end else begin
         status_q <= status_nxt_i;
      end
   end

   // Flags: the host sets, the device clears, and a set beats a clear
   assign set_mask = (h_wr_i && h_adr_i == AW'(OFS_FLAGS)) ? h_wd_i : '0;
   assign clr_mask = (d_wr_i && d_adr_i == AW'(OFS_FLAGS)) ? d_wd_i : '0;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         flags_q <= '0;
      end else begin
         flags_q <= (flags_q & ~clr_mask) | set_mask;
      end
   end

   // Plain read/write bytes; on a collision the host value is stored
   for (genvar i = OFS_SHARED; i < NREG; i++) begin : g_plain
      always_ff @(posedge clk_i) begin
         if (rst_i) begin
            store[i] <= '0;
         end else if (h_wr_i && h_adr_i == AW'(i)) begin
            store[i] <= h_wd_i;
         end else if (d_wr_i && d_adr_i == AW'(i)) begin
            store[i] <= d_wd_i;
         end
      end
   end

   // Read view: offset 3 reads the switches, not the LED byte
   assign view[OFS_STATUS] = {status_q.hold, status_q.host_mem, {(DW-2){1'b0}}};
   assign view[OFS_FLAGS]  = flags_q;
   for (genvar i = OFS_SHARED; i < NREG; i++) begin : g_view
      if (i == OFS_IO) begin : g_sw
         assign view[i] = sw_sync_i;
      end else begin : g_st
         assign view[i] = store[i];
      end
   end

   for (genvar n = 0; n < NDIG; n++) begin : g_digit
      assign digit_o[n*DW +: DW] = store[OFS_DIGIT0 + n];
   end

   assign h_rval_o = view[h_adr_i];
   assign d_rval_o = view[d_adr_i];
   assign status_o = status_q;
   assign flags_o  = flags_q;
   assign led_o    = store[OFS_IO];
endmodule

// File: rtl/hostdev_mailbox.sv
module hostdev_mailbox
   import hdmbx_pkg::*;
#(
   parameter int DW          = 8,
   parameter int NDIG        = 4,
   parameter int SYNC_STAGES = 2,
   localparam int AW         = $clog2(OFS_DIGIT0 + NDIG)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               hst_cyc_i,
   input  logic               hst_stb_i,
   input  logic               hst_we_i,
   input  logic [AW-1:0]      hst_adr_i,
   input  logic [DW-1:0]      hst_dat_i,
   output logic [DW-1:0]      hst_dat_o,
   output logic               hst_ack_o,
   input  logic               dev_cyc_i,
   input  logic               dev_stb_i,
   input  logic               dev_we_i,
   input  logic [AW-1:0]      dev_adr_i,
   input  logic [DW-1:0]      dev_dat_i,
   output logic [DW-1:0]      dev_dat_o,
   output logic               dev_ack_o,
   input  logic               ctl_hold_i,
   input  logic               ctl_host_mem_i,
   input  logic [DW-1:0]      sw_i,
   output logic               dev_hold_o,
   output logic               host_mem_o,
   output logic [DW-1:0]      irq_o,
   output logic [DW-1:0]      led_o,
   output logic [NDIG*DW-1:0] digit_o
);
   if (DW < 2) begin : g_bad_dw
      $error("hostdev_mailbox needs DW >= 2 for the status bits");
   end
   if (NDIG < 1) begin : g_bad_ndig
      $error("hostdev_mailbox needs at least one digit");
   end
   if ((OFS_DIGIT0 + NDIG) != (1 << AW)) begin : g_bad_map
      $error("register count must fill the address space");
   end

   logic          h_wr, d_wr;
   logic [DW-1:0] h_rval, d_rval, sw_sync;
   status_t       status;

   hdmbx_sync #(.W(DW), .STAGES(SYNC_STAGES)) u_sw_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .d_i   (sw_i),
      .q_o   (sw_sync)
   );

   hdmbx_port #(.DW(DW)) u_hst_port (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .cyc_i    (hst_cyc_i),
      .stb_i    (hst_stb_i),
      .we_i     (hst_we_i),
      .rd_val_i (h_rval),
      .dat_o    (hst_dat_o),
      .ack_o    (hst_ack_o),
      .wr_go_o  (h_wr)
   );

   hdmbx_port #(.DW(DW)) u_dev_port (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .cyc_i    (dev_cyc_i),
      .stb_i    (dev_stb_i),
      .we_i     (dev_we_i),
      .rd_val_i (d_rval),
      .dat_o    (dev_dat_o),
      .ack_o    (dev_ack_o),
      .wr_go_o  (d_wr)
   );

   hdmbx_regs #(.DW(DW), .NDIG(NDIG), .AW(AW)) u_regs (
      .clk_i        (clk_i),
      .rst_i        (rst_i),
      .h_wr_i       (h_wr),
      .h_adr_i      (hst_adr_i),
      .h_wd_i       (hst_dat_i),
      .d_wr_i       (d_wr),
      .d_adr_i      (dev_adr_i),
      .d_wd_i       (dev_dat_i),
      .sw_sync_i    (sw_sync),
      .status_nxt_i ('{hold: ctl_hold_i, host_mem: ctl_host_mem_i}),
      .status_o     (status),
      .flags_o      (irq_o),
      .led_o        (led_o),
      .digit_o      (digit_o),
      .h_rval_o     (h_rval),
      .d_rval_o     (d_rval)
   );

   assign dev_hold_o = status.hold;
   assign host_mem_o = status.host_mem;
endmodule

// File: rtl/hdmbx_checker.sv
module hdmbx_checker #(
   parameter int DW   = 8,
   parameter int NDIG = 4,
   parameter int AW   = 3
) (
   input logic          clk_i,
   input logic          rst_i,
   input logic          hst_cyc_i,
   input logic          hst_stb_i,
   input logic          hst_we_i,
   input logic [AW-1:0] hst_adr_i,
   input logic [DW-1:0] hst_dat_i,
   input logic          hst_ack_o,
   input logic          dev_cyc_i,
   input logic          dev_stb_i,
   input logic          dev_we_i,
   input logic [AW-1:0] dev_adr_i,
   input logic [DW-1:0] dev_dat_i,
   input logic          dev_ack_o,
   input logic          ctl_hold_i,
   input logic          ctl_host_mem_i,
   input logic          dev_hold_o,
   input logic          host_mem_o,
   input logic [DW-1:0] irq_o,
   input logic [DW-1:0] led_o
);
   logic hw_go, dw_go, hw_flag, dw_flag, hw_led;

   assign hw_go   = hst_cyc_i && hst_stb_i && hst_we_i && !hst_ack_o;
   assign dw_go   = dev_cyc_i && dev_stb_i && dev_we_i && !dev_ack_o;
   assign hw_flag = hw_go && hst_adr_i == AW'(1);
   assign dw_flag = dw_go && dev_adr_i == AW'(1);
   assign hw_led  = hw_go && hst_adr_i == AW'(3);

   assert_hst_ack_gated_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      hst_ack_o |-> (hst_cyc_i && hst_stb_i));
   assert_dev_ack_gated_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      dev_ack_o |-> (dev_cyc_i && dev_stb_i));
   assert_hst_ack_after_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      hst_ack_o |-> $past(hst_cyc_i && hst_stb_i));
   assert_dev_ack_after_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      dev_ack_o |-> $past(dev_cyc_i && dev_stb_i));
   assert_status_track_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (dev_hold_o == $past(ctl_hold_i)) && (host_mem_o == $past(ctl_host_mem_i)));
   assert_flag_set_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      hw_flag |=> ((irq_o & $past(hst_dat_i)) == $past(hst_dat_i)));
   assert_flag_clear_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (dw_flag && !hw_flag) |=> ((irq_o & $past(dev_dat_i)) == '0));
   assert_flag_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (!hw_flag && !dw_flag) |=> (irq_o == $past(irq_o)));
   assert_led_write_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      hw_led |=> (led_o == $past(hst_dat_i)));
endmodule

bind hostdev_mailbox hdmbx_checker #(.DW(DW), .NDIG(NDIG), .AW(AW)) u_hdmbx_checker (
   .clk_i          (clk_i),
   .rst_i          (rst_i),
   .hst_cyc_i      (hst_cyc_i),
   .hst_stb_i      (hst_stb_i),
   .hst_we_i       (hst_we_i),
   .hst_adr_i      (hst_adr_i),
   .hst_dat_i      (hst_dat_i),
   .hst_ack_o      (hst_ack_o),
   .dev_cyc_i      (dev_cyc_i),
   .dev_stb_i      (dev_stb_i),
   .dev_we_i       (dev_we_i),
   .dev_adr_i      (dev_adr_i),
   .dev_dat_i      (dev_dat_i),
   .dev_ack_o      (dev_ack_o),
   .ctl_hold_i     (ctl_hold_i),
   .ctl_host_mem_i (ctl_host_mem_i),
   .dev_hold_o     (dev_hold_o),
   .host_mem_o     (host_mem_o),
   .irq_o          (irq_o),
   .led_o          (led_o)
);

// File: tb/hostdev_mailbox_bench.sv
`timescale 1ns/1ps
module hostdev_mailbox_bench;
   logic        clk_i = 1'b0;
   logic        rst_i = 1'b1;
   logic        hst_cyc_i = 0, hst_stb_i = 0, hst_we_i = 0;
   logic [2:0]  hst_adr_i = 0;
   logic [7:0]  hst_dat_i = 0;
   logic [7:0]  hst_dat_o;
   logic        hst_ack_o;
   logic        dev_cyc_i = 0, dev_stb_i = 0, dev_we_i = 0;
   logic [2:0]  dev_adr_i = 0;
   logic [7:0]  dev_dat_i = 0;
   logic [7:0]  dev_dat_o;
   logic        dev_ack_o;
   logic        ctl_hold_i = 0, ctl_host_mem_i = 0;
   logic [7:0]  sw_i = 0;
   logic        dev_hold_o, host_mem_o;
   logic [7:0]  irq_o, led_o;
   logic [31:0] digit_o;

   int tests = 0;
   int fails = 0;

   always #5 clk_i = ~clk_i;

   hostdev_mailbox u_hostdev_mailbox (.*);

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // One access on one port; drives at a falling edge, samples at falling edges
   task automatic xfer(input bit dv, input bit we, input logic [2:0] a,
                       input logic [7:0] wd, output logic [7:0] rd);
      @(negedge clk_i);
      if (dv) begin
         dev_cyc_i = 1; dev_stb_i = 1; dev_we_i = we; dev_adr_i = a; dev_dat_i = wd;
      end else begin
         hst_cyc_i = 1; hst_stb_i = 1; hst_we_i = we; hst_adr_i = a; hst_dat_i = wd;
      end
      #1;
      chk((dv ? dev_ack_o : hst_ack_o) == 1'b0, "R2 no ack before clock", dv ? dev_ack_o : hst_ack_o, 0);
      @(negedge clk_i);
      chk((dv ? dev_ack_o : hst_ack_o) == 1'b1, "R2 ack one clock later", dv ? dev_ack_o : hst_ack_o, 1);
      rd = dv ? dev_dat_o : hst_dat_o;
      if (dv) begin
         dev_cyc_i = 0; dev_stb_i = 0; dev_we_i = 0;
      end else begin
         hst_cyc_i = 0; hst_stb_i = 0; hst_we_i = 0;
      end
      #1;
      chk((dv ? dev_ack_o : hst_ack_o) == 1'b0, "R2 ack drops with stb", dv ? dev_ack_o : hst_ack_o, 0);
   endtask

   task automatic wr(input bit dv, input logic [2:0] a, input logic [7:0] wd);
      logic [7:0] junk;
      xfer(dv, 1'b1, a, wd, junk);
   endtask

   task automatic rd_chk(input bit dv, input logic [2:0] a, input logic [7:0] exp, input string rq);
      logic [7:0] got;
      xfer(dv, 1'b0, a, 8'h00, got);
      chk(got === exp, rq, got, exp);
   endtask

   // Both ports write in the same cycle
   task automatic dual_wr(input logic [2:0] ha, input logic [7:0] hd,
                          input logic [2:0] da, input logic [7:0] dd);
      @(negedge clk_i);
      hst_cyc_i = 1; hst_stb_i = 1; hst_we_i = 1; hst_adr_i = ha; hst_dat_i = hd;
      dev_cyc_i = 1; dev_stb_i = 1; dev_we_i = 1; dev_adr_i = da; dev_dat_i = dd;
      @(negedge clk_i);
      hst_cyc_i = 0; hst_stb_i = 0; hst_we_i = 0;
      dev_cyc_i = 0; dev_stb_i = 0; dev_we_i = 0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk_i);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      logic [7:0] v, w, c, exp;

      // R1 reset state, with status inputs at 0 while in reset
      repeat (3) @(negedge clk_i);
      chk(dev_hold_o == 1 && host_mem_o == 1, "R1 status during reset", {dev_hold_o, host_mem_o}, 2'b11);
      chk(irq_o == 0 && led_o == 0 && digit_o == 0, "R1 regs cleared", {irq_o, led_o}, 0);
      chk(hst_ack_o == 0 && dev_ack_o == 0, "R1 no ack", {hst_ack_o, dev_ack_o}, 0);
      ctl_hold_i = 1; ctl_host_mem_i = 1;
      rst_i = 0;

      // R3 status follows inputs one clock later, immune to writes
      for (int k = 0; k < 4; k++) begin
         @(negedge clk_i);
         ctl_hold_i = k[1]; ctl_host_mem_i = k[0];
         @(negedge clk_i);
         chk({dev_hold_o, host_mem_o} == k[1:0], "R3 status tracks inputs", {dev_hold_o, host_mem_o}, k[1:0]);
         wr(k[0], 3'd0, 8'hFF);
         wr(!k[0], 3'd0, 8'h00);
         rd_chk(0, 3'd0, {k[1:0], 6'b0}, "R3 status read host");
         rd_chk(1, 3'd0, {k[1:0], 6'b0}, "R3 status read device");
      end

      // R4/R5 flag sweep
      for (int i = 0; i < 256; i++) begin
         v = 8'(i);
         w = 8'((i * 13 + 5) & 255);
         c = 8'((i * 37 + 11) & 255);
         wr(1, 3'd1, 8'hFF);
         chk(irq_o == 8'h00, "R5 clear all", irq_o, 0);
         wr(0, 3'd1, v);
         chk(irq_o == v, "R4 host set", irq_o, v);
         wr(0, 3'd1, w);
         chk(irq_o == (v | w), "R4 zeros keep bits", irq_o, v | w);
         wr(1, 3'd1, c);
         exp = (v | w) & ~c;
         chk(irq_o == exp, "R5 device clear", irq_o, exp);
         if ((i % 16) == 0) begin
            rd_chk(0, 3'd1, exp, "R4 host read flags");
            rd_chk(1, 3'd1, exp, "R5 device read flags");
         end
      end

      // R6 set beats clear; R7 host wins on collision
      for (int i = 0; i < 32; i++) begin
         v = 8'((i * 29 + 3) & 255);
         w = 8'((i * 71 + 90) & 255);
         c = 8'((i * 45 + 17) & 255);
         wr(1, 3'd1, 8'hFF);
         wr(0, 3'd1, v);
         dual_wr(3'd1, w, 3'd1, c);
         exp = (v & ~c) | w;
         chk(irq_o == exp, "R6 set beats clear", irq_o, exp);
         dual_wr(3'd2, w, 3'd2, c);
         rd_chk(1, 3'd2, w, "R7 host wins shared byte");
         dual_wr(3'(4 + (i % 4)), v, 3'(4 + (i % 4)), c);
         exp = v;
         chk(digit_o[(i % 4) * 8 +: 8] == exp, "R7 host wins digit", digit_o[(i % 4) * 8 +: 8], exp);
      end

      // R7 shared byte and R9 digit bytes, written on one port and read on the other
      for (int a = 2; a < 8; a++) begin
         if (a == 3) continue;
         for (int k = 0; k < 16; k++) begin
            v = 8'((a * 53 + k * 17) & 255);
            wr(k[0], 3'(a), v);
            rd_chk(!k[0], 3'(a), v, a == 2 ? "R7 shared byte" : "R9 digit readback");
            if (a >= 4) begin
               chk(digit_o[(a - 4) * 8 +: 8] == v, "R9 digit placement", digit_o[(a - 4) * 8 +: 8], v);
            end
         end
      end

      // R8 LEDs written, switches read through the synchroniser
      for (int k = 0; k < 16; k++) begin
         v = 8'((k * 91 + 7) & 255);
         w = 8'((k * 23 + 200) & 255);
         wr(k[0], 3'd3, v);
         chk(led_o == v, "R8 led write", led_o, v);
         @(negedge clk_i);
         sw_i = w;
         rd_chk(k[1], 3'd3, sw_i == w && k > 0 ? 8'(((k - 1) * 23 + 200) & 255) : 8'h00, "R8 switch not yet visible");
         repeat (3) @(negedge clk_i);
         rd_chk(!k[1], 3'd3, w, "R8 switch read");
         chk(led_o == v, "R8 led unaffected by read", led_o, v);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule